// File: doc/BRIEF.md
# Double-Precision to Signed Integer Converter

This block turns an IEEE 754 binary64 value into a 64-bit two's-complement integer. Each operation carries its own 2-bit rounding selector and its own inexact-enable flag. The block is a fixed three-stage pipeline. It accepts a new operand on every clock and has no stall path. A valid strobe travels with each operand and comes out beside its result.

The first stage splits the operand and classifies it. The second stage aligns the significand to the integer point and keeps a guard bit and a sticky bit. The third stage applies the selected rounding direction, negates the result when needed, and replaces the value with a saturated result for exceptional inputs.

Top module: `f2i_conv`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly three rising edges earlier. A new operand may enter on every cycle, including back-to-back cycles and cycles that follow a gap.
- R2: Selector value 2'b00 rounds to the nearest integer. An exact tie goes to the even integer, so 2.5 gives 2, 3.5 gives 4 and -2.5 gives -2.
- R3: Selector value 2'b01 rounds toward zero.
- R4: Selector value 2'b10 rounds toward negative infinity, so -0.5 gives -1.
- R5: Selector value 2'b11 rounds toward positive infinity, so 0.5 gives 1.
- R6: `out_inexact` is 1 only when `in_inexact_en` was 1 and at least one discarded fraction bit was nonzero. With the enable at 0 it is always 0.
- R7: A NaN operand (exponent field all ones, fraction nonzero) gives 64'h8000_0000_0000_0000 with `out_invalid`=1, `out_overflow`=0 and `out_inexact`=0.
- R8: Infinities and finite values outside [-2^63, 2^63-1] give 64'h7FFF_FFFF_FFFF_FFFF for a positive sign and 64'h8000_0000_0000_0000 for a negative sign, with `out_overflow`=1, `out_invalid`=0 and `out_inexact`=0. The value -2^63 itself converts exactly and raises no flag.
- R9: Zeros of either sign and subnormal operands (exponent field zero) convert correctly in every rounding direction. For example, the smallest positive subnormal rounds up to 1 under selector 2'b11.
- R10: After reset, and in every cycle where `out_valid` is 0, `out_result` and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 64 | binary64 operand |
| in_rmode | input | 2 | Rounding selector: 00 nearest-even, 01 toward zero, 10 down, 11 up |
| in_inexact_en | input | 1 | Allows `out_inexact` to be raised for this operation |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 64 | Signed integer result |
| out_inexact | output | 1 | Fraction bits were discarded (when enabled) |
| out_invalid | output | 1 | Operand was NaN |
| out_overflow | output | 1 | Operand was infinite or out of range; result saturated |

## Verification
Every result, every flag and the valid strobe are due on the third rising edge after the edge that captured the operand; nothing in the block arrives earlier or later. The bench drives each operand just after a falling edge and writes its computed expectation into a four-entry ring. At each later falling edge, before it drives the next operand, it compares the outputs against the ring entry written three falling edges earlier. Idle cycles inserted into the stream check both that the strobe keeps its alignment and that the outputs stay quiet.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int EXP_W   = 11;
    localparam int MAN_W   = 52;
    localparam int INT_W   = 64;
    localparam int OP_W    = 1 + EXP_W + MAN_W;
    localparam int SIG_W   = MAN_W + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_S_W = EXP_W + 2;
    localparam int SH_W    = $clog2(SIG_W + 2);

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_DOWN = 2'b10,
        RM_UP   = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        CL_NUM = 2'd0,
        CL_NAN = 2'd1,
        CL_INF = 2'd2,
        CL_OVF = 2'd3
    } cls_e;

    typedef struct packed {
        logic                        valid;
        logic                        sign;
        cls_e                        cls;
        logic [SIG_W-1:0]            sig;
        logic signed [EXP_S_W-1:0]   exp_unb;
        rmode_e                      rmode;
        logic                        ixen;
    } unpk_t;

    typedef struct packed {
        logic              valid;
        logic              sign;
        cls_e              cls;
        logic [INT_W-1:0]  mag;
        logic              guard;
        logic              sticky;
        rmode_e            rmode;
        logic              ixen;
    } algn_t;

    typedef struct packed {
        logic              valid;
        logic [INT_W-1:0]  result;
        logic              inexact;
        logic              invalid;
        logic              overflow;
    } rslt_t;

    typedef struct packed {
        unpk_t st1;
        algn_t st2;
        rslt_t st3;
    } pipe_t;

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [OP_W-1:0]             op,
    output logic                        sign,
    output cls_e                        cls,
    output logic [SIG_W-1:0]            sig,
    output logic signed [EXP_S_W-1:0]   exp_unb
);
    localparam logic [EXP_W-1:0] EXP_ONES = '1;
    localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(1);
    localparam logic signed [EXP_S_W-1:0] BIAS_S = EXP_S_W'(BIAS);

    logic [EXP_W-1:0] efield;
    logic [MAN_W-1:0] ffield;
    logic [EXP_W-1:0] e_eff;

    always_comb begin
        sign   = op[OP_W-1];
        efield = op[MAN_W +: EXP_W];
        ffield = op[MAN_W-1:0];
        if (efield == EXP_ONES) begin
            cls = (ffield != '0) ? CL_NAN : CL_INF;
        end else begin
            cls = CL_NUM;
        end
        sig     = {(efield != '0), ffield};
        // subnormals share the scale of the smallest normal exponent
        e_eff   = (efield == '0) ? EXP_ONE : efield;
        exp_unb = $signed({2'b00, e_eff}) - BIAS_S;
    end

endmodule

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
(
    input  logic                        sign,
    input  cls_e                        cls_in,
    input  logic [SIG_W-1:0]            sig,
    input  logic signed [EXP_S_W-1:0]   exp_unb,
    output cls_e                        cls_out,
    output logic [INT_W-1:0]            mag,
    output logic                        guard,
    output logic                        sticky
);
    localparam int EXT_W = 2 * SIG_W + 1;
    localparam logic signed [EXP_S_W-1:0] E_TOP  = EXP_S_W'(INT_W - 1);
    localparam logic signed [EXP_S_W-1:0] E_MAN  = EXP_S_W'(MAN_W);
    localparam logic signed [EXP_S_W-1:0] E_CLMP = EXP_S_W'(SIG_W + 1);
    localparam logic [SIG_W-1:0] SIG_ONE  = {1'b1, {MAN_W{1'b0}}};
    localparam logic [INT_W-1:0] MAG_MINV = {1'b1, {(INT_W-1){1'b0}}};

    logic signed [EXP_S_W-1:0] rdist;
    logic signed [EXP_S_W-1:0] ldist;
    logic [SH_W-1:0]           rsh;
    logic [EXT_W-1:0]          ext;
    logic [EXT_W-1:0]          shifted;

    always_comb begin
        cls_out = cls_in;
        mag     = '0;
        guard   = 1'b0;
        sticky  = 1'b0;
        rdist   = E_MAN - exp_unb;
        ldist   = exp_unb - E_MAN;
        rsh     = (rdist > E_CLMP) ? SH_W'(SIG_W + 1) : rdist[SH_W-1:0];
        ext     = {sig, {(SIG_W+1){1'b0}}};
        shifted = ext >> rsh;
        if (cls_in == CL_INF) begin
            cls_out = CL_OVF;
        end else if (cls_in == CL_NUM) begin
            if (exp_unb >= E_TOP) begin
                // only -2^63 survives at or above the top exponent
                if (sign && (exp_unb == E_TOP) && (sig == SIG_ONE)) begin
                    mag = MAG_MINV;
                end else begin
                    cls_out = CL_OVF;
                end
            end else if (exp_unb >= E_MAN) begin
                mag = {{(INT_W-SIG_W){1'b0}}, sig} << ldist;
            end else begin
                mag    = {{(INT_W-SIG_W){1'b0}}, shifted[EXT_W-1:SIG_W+1]};
                guard  = shifted[SIG_W];
                sticky = |shifted[SIG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  logic              sign,
    input  cls_e              cls,
    input  logic [INT_W-1:0]  mag,
    input  logic              guard,
    input  logic              sticky,
    input  rmode_e            rmode,
    input  logic              ixen,
    output logic [INT_W-1:0]  result,
    output logic              inexact,
    output logic              invalid,
    output logic              overflow
);
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};

    logic             lost;
    logic             bump;
    logic [INT_W-1:0] mrnd;

    always_comb begin
        lost = guard | sticky;
        unique case (rmode)
            RM_NEAR: bump = guard & (sticky | mag[0]);
            RM_ZERO: bump = 1'b0;
            RM_DOWN: bump = sign & lost;
            RM_UP:   bump = ~sign & lost;
            default: bump = 1'b0;
        endcase
        mrnd     = mag + INT_W'(bump);
        result   = '0;
        inexact  = 1'b0;
        invalid  = 1'b0;
        overflow = 1'b0;
        unique case (cls)
            CL_NAN: begin
                result  = INT_MIN;
                invalid = 1'b1;
            end
            CL_NUM: begin
                result  = sign ? (~mrnd + INT_W'(1)) : mrnd;
                inexact = lost & ixen;
            end
            default: begin
                result   = sign ? INT_MIN : INT_MAX;
                overflow = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
    import f2i_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_operand,
    input  logic [1:0]        in_rmode,
    input  logic              in_inexact_en,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_result,
    output logic              out_inexact,
    output logic              out_invalid,
    output logic              out_overflow
);
    pipe_t pipe_d;
    pipe_t pipe_q;

    logic                       u_sign;
    cls_e                       u_cls;
    logic [SIG_W-1:0]           u_sig;
    logic signed [EXP_S_W-1:0]  u_exp;

    cls_e                       a_cls;
    logic [INT_W-1:0]           a_mag;
    logic                       a_guard;
    logic                       a_sticky;

    logic [INT_W-1:0]           r_result;
    logic                       r_inexact;
    logic                       r_invalid;
    logic                       r_overflow;

    f2i_unpack u_unpack (
        .op      (in_operand),
        .sign    (u_sign),
        .cls     (u_cls),
        .sig     (u_sig),
        .exp_unb (u_exp)
    );

    f2i_align u_align (
        .sign    (pipe_q.st1.sign),
        .cls_in  (pipe_q.st1.cls),
        .sig     (pipe_q.st1.sig),
        .exp_unb (pipe_q.st1.exp_unb),
        .cls_out (a_cls),
        .mag     (a_mag),
        .guard   (a_guard),
        .sticky  (a_sticky)
    );

    f2i_round u_round (
        .sign     (pipe_q.st2.sign),
        .cls      (pipe_q.st2.cls),
        .mag      (pipe_q.st2.mag),
        .guard    (pipe_q.st2.guard),
        .sticky   (pipe_q.st2.sticky),
        .rmode    (pipe_q.st2.rmode),
        .ixen     (pipe_q.st2.ixen),
        .result   (r_result),
        .inexact  (r_inexact),
        .invalid  (r_invalid),
        .overflow (r_overflow)
    );

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.st1.valid   = in_valid;
        pipe_d.st1.sign    = u_sign;
        pipe_d.st1.cls     = u_cls;
        pipe_d.st1.sig     = u_sig;
        pipe_d.st1.exp_unb = u_exp;
        pipe_d.st1.rmode   = rmode_e'(in_rmode);
        pipe_d.st1.ixen    = in_inexact_en;

        pipe_d.st2.valid   = pipe_q.st1.valid;
        pipe_d.st2.sign    = pipe_q.st1.sign;
        pipe_d.st2.cls     = a_cls;
        pipe_d.st2.mag     = a_mag;
        pipe_d.st2.guard   = a_guard;
        pipe_d.st2.sticky  = a_sticky;
        pipe_d.st2.rmode   = pipe_q.st1.rmode;
        pipe_d.st2.ixen    = pipe_q.st1.ixen;

        pipe_d.st3 = '0;
        if (pipe_q.st2.valid) begin
            pipe_d.st3.valid    = 1'b1;
            pipe_d.st3.result   = r_result;
            pipe_d.st3.inexact  = r_inexact;
            pipe_d.st3.invalid  = r_invalid;
            pipe_d.st3.overflow = r_overflow;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid    = pipe_q.st3.valid;
    assign out_result   = pipe_q.st3.result;
    assign out_inexact  = pipe_q.st3.inexact;
    assign out_invalid  = pipe_q.st3.invalid;
    assign out_overflow = pipe_q.st3.overflow;

endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk
    import f2i_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sign,
    input logic [1:0]        in_rmode,
    input logic              in_inexact_en,
    input logic              out_valid,
    input logic [INT_W-1:0]  out_result,
    input logic              out_inexact,
    input logic              out_invalid,
    input logic              out_overflow
);
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R1

    AST_TRUNC_KEEPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && out_valid && !out_invalid && !out_overflow
         && ($past(in_rmode, 3) == 2'b01) && !$past(in_sign, 3))
        |-> !out_result[INT_W-1]); // R3

    AST_INEXACT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 2'd3) && out_inexact) |-> $past(in_inexact_en, 3)); // R6

    AST_NAN_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_invalid)
        |-> ((out_result == INT_MIN) && !out_overflow && !out_inexact)); // R7

    AST_SAT_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow)
        |-> (((out_result == INT_MIN) || (out_result == INT_MAX)) && !out_inexact)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ((out_result == '0) && !out_inexact && !out_invalid && !out_overflow)); // R10

endmodule

bind f2i_conv f2i_conv_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_sign       (in_operand[63]),
    .in_rmode      (in_rmode),
    .in_inexact_en (in_inexact_en),
    .out_valid     (out_valid),
    .out_result    (out_result),
    .out_inexact   (out_inexact),
    .out_invalid   (out_invalid),
    .out_overflow  (out_overflow)
);

// File: tb/f2i_conv_tb_top.sv
module f2i_conv_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_rmode = '0;
    logic        in_inexact_en = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_inexact;
    logic        out_invalid;
    logic        out_overflow;

    always #4 clk = ~clk;

    f2i_conv dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_operand    (in_operand),
        .in_rmode      (in_rmode),
        .in_inexact_en (in_inexact_en),
        .out_valid     (out_valid),
        .out_result    (out_result),
        .out_inexact   (out_inexact),
        .out_invalid   (out_invalid),
        .out_overflow  (out_overflow)
    );

    typedef struct packed {
        logic [63:0] res;
        logic        ix;
        logic        inv;
        logic        ovf;
    } mres_t;

    int    n_chk = 0;
    int    n_bad = 0;
    int    slot  = 0;
    logic  ev_v   [4];
    mres_t ev_r   [4];
    string ev_tag [4];

    localparam logic [63:0] LMIN = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LMAX = 64'h7FFF_FFFF_FFFF_FFFF;

    // arithmetic reference: quotient and remainder against a power of two
    function automatic mres_t model(logic [63:0] op, logic [1:0] rm, logic ixen);
        mres_t        r;
        logic         s;
        int           e;
        int           sc;
        int           sh;
        int           cmp;
        logic         nz;
        logic         huge;
        logic         up;
        logic [127:0] m;
        logic [127:0] q;
        logic [127:0] rem;
        logic [127:0] lim;
        r    = '0;
        s    = op[63];
        e    = int'(op[62:52]);
        cmp  = -1;
        nz   = 1'b0;
        huge = 1'b0;
        q    = '0;
        if (e == 2047) begin
            if (op[51:0] != 0) begin
                r.res = LMIN; r.inv = 1'b1;
            end else begin
                r.res = s ? LMIN : LMAX; r.ovf = 1'b1;
            end
            return r;
        end
        m  = {75'b0, (e != 0), op[51:0]};
        sc = ((e == 0) ? 1 : e) - 1075;
        if (m == 0) begin
            q = '0;
        end else if (sc >= 0) begin
            if (sc > 70) huge = 1'b1;
            else q = m << sc;
        end else begin
            sh = -sc;
            if (sh >= 54) begin
                q = '0; nz = 1'b1; cmp = -1;
            end else begin
                q   = m >> sh;
                rem = m - (q << sh);
                nz  = (rem != 0);
                if ((rem << 1) > (128'd1 << sh)) cmp = 1;
                else if ((rem << 1) == (128'd1 << sh)) cmp = 0;
                else cmp = -1;
            end
        end
        case (rm)
            2'b00:   up = nz && ((cmp > 0) || ((cmp == 0) && q[0]));
            2'b01:   up = 1'b0;
            2'b10:   up = s && nz;
            default: up = !s && nz;
        endcase
        q   = q + {127'b0, up};
        lim = s ? (128'd1 << 63) : ((128'd1 << 63) - 1);
        if (huge || (q > lim)) begin
            r.res = s ? LMIN : LMAX;
            r.ovf = 1'b1;
        end else begin
            r.res = s ? (64'd0 - q[63:0]) : q[63:0];
            r.ix  = nz && ixen;
        end
        return r;
    endfunction

    function automatic string tag_of(logic [63:0] op, logic [1:0] rm, mres_t r);
        if (r.inv) return "R7";
        if (r.ovf) return "R8";
        if (op[62:52] == 11'd0) return "R9";
        if (op == 64'hC3E0_0000_0000_0000) return "R8";
        case (rm)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // one cycle: compare the entry issued three falling edges ago, then drive
    task automatic issue(logic v, logic [63:0] op, logic [1:0] rm, logic ixen);
        int    ci;
        int    wi;
        mres_t r;
        @(negedge clk);
        ci = (slot + 1) % 4;
        wi = slot % 4;
        check("R1", "out_valid", {63'b0, out_valid}, {63'b0, ev_v[ci]});
        if (ev_v[ci]) begin
            check(ev_tag[ci], "result", out_result, ev_r[ci].res);
            check("R6", "inexact", {63'b0, out_inexact}, {63'b0, ev_r[ci].ix});
            check("R7", "invalid", {63'b0, out_invalid}, {63'b0, ev_r[ci].inv});
            check("R8", "overflow", {63'b0, out_overflow}, {63'b0, ev_r[ci].ovf});
        end else begin
            check("R10", "idle outputs",
                  out_result | {61'b0, out_inexact, out_invalid, out_overflow}, 64'd0);
        end
        r          = model(op, rm, ixen);
        ev_v[wi]   = v;
        ev_r[wi]   = r;
        ev_tag[wi] = tag_of(op, rm, r);
        in_valid      = v;
        in_operand    = op;
        in_rmode      = rm;
        in_inexact_en = ixen;
        slot++;
    endtask

    function automatic logic [51:0] mpat(int k);
        case (k)
            0:       return 52'h0;
            1:       return 52'h1;
            2:       return 52'h8_0000_0000_0000;
            3:       return 52'h8_0000_0000_0001;
            4:       return 52'hF_FFFF_FFFF_FFFF;
            5:       return 52'h5_5555_5555_5555;
            6:       return 52'h4_0000_0000_0000;
            default: return 52'h3_A5C9_6F01_2345;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] dir [16];
        int          gap;
        for (int i = 0; i < 4; i++) begin
            ev_v[i]   = 1'b0;
            ev_r[i]   = '0;
            ev_tag[i] = "R10";
        end
        dir[0]  = 64'h4004_0000_0000_0000; // 2.5
        dir[1]  = 64'h400C_0000_0000_0000; // 3.5
        dir[2]  = 64'hC004_0000_0000_0000; // -2.5
        dir[3]  = 64'h3FE0_0000_0000_0000; // 0.5
        dir[4]  = 64'hBFE0_0000_0000_0000; // -0.5
        dir[5]  = 64'h3FF8_0000_0000_0000; // 1.5
        dir[6]  = 64'h7FF8_0000_0000_0000; // quiet NaN
        dir[7]  = 64'hFFF0_0000_0000_0001; // signalling NaN, negative
        dir[8]  = 64'h7FF0_0000_0000_0000; // +inf
        dir[9]  = 64'hFFF0_0000_0000_0000; // -inf
        dir[10] = 64'hC3E0_0000_0000_0000; // -2^63 exact
        dir[11] = 64'h43E0_0000_0000_0000; // +2^63
        dir[12] = 64'h43DF_FFFF_FFFF_FFFF; // largest below 2^63
        dir[13] = 64'hC3E0_0000_0000_0001; // just below -2^63
        dir[14] = 64'h0000_0000_0000_0001; // smallest subnormal
        dir[15] = 64'h8000_0000_0000_0000; // -0

        repeat (3) @(negedge clk);
        // R10: quiet outputs while reset is held
        check("R10", "reset outputs",
              out_result | {60'b0, out_valid, out_inexact, out_invalid, out_overflow}, 64'd0);
        rst_n = 1'b1;

        for (int d = 0; d < 16; d++) begin
            for (int rm = 0; rm < 4; rm++) begin
                issue(1'b1, dir[d], 2'(rm), 1'b1);
            end
        end
        issue(1'b1, dir[0], 2'b00, 1'b0); // R6 enable low on inexact value
        issue(1'b0, 64'h0, 2'b00, 1'b0);

        gap = 0;
        for (int sg = 0; sg < 2; sg++) begin
            for (int ei = -1; ei <= 100; ei++) begin
                for (int k = 0; k < 8; k++) begin
                    for (int rm = 0; rm < 4; rm++) begin
                        logic [10:0] ef;
                        ef = (ei < 0) ? 11'd0 : 11'(990 + ei);
                        issue(1'b1, {sg[0], ef, mpat(k)}, 2'(rm), k[0] ^ rm[0]);
                        gap++;
                        if (gap % 7 == 0) issue(1'b0, 64'hDEAD_BEEF_0000_0000, 2'b11, 1'b1);
                    end
                end
            end
        end
        repeat (4) issue(1'b0, 64'h0, 2'b00, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule